// File: doc/BRIEF.md
# Glitch-free system clock selector

This block picks the system clock from two unrelated clock inputs: an oscillator clock and a PLL clock. A select input asks for the PLL source. A self-clock-mode input forces the PLL source whatever the select input says. The handover runs in two stages. The old source is first turned off inside its own clock domain. Only after that is the new source turned on inside its own domain. Between the two stages no clock reaches the output, so the system clock never shows a runt pulse. A busy flag covers the whole handover. A select change that arrives while a handover is running is held and is applied once the running handover has finished.

From the selected clock the block makes a core clock at the system rate and a bus clock at half that rate. The bus divider is cleared while no source is enabled, so it starts afresh at the first edge of the new source. The block also holds the PLL enable flag. A write that would clear this flag is refused while the PLL is the target or the active source. Two gated copies of the oscillator clock feed a watchdog timer and a periodic-interrupt timer. Each copy follows its own enable, stop-mode and wait-mode settings.

Top module: `sysclk_selector`

## Requirements
- R1: With self-clock mode off, `pll_sel`=1 makes `sys_clk` follow `pll_clk` and `pll_sel`=0 makes it follow `osc_clk`, once `busy` has dropped.
- R2: While `scm_force`=1, `sys_clk` follows `pll_clk` even when `pll_sel`=0. Releasing `scm_force` with `pll_sel`=0 returns the source to `osc_clk`.
- R3: A write (`pll_en_wr`=1 at an `osc_clk` rising edge) loads `pll_en_wdata` into `pll_en`. A write of 0 leaves `pll_en` at 1 while the PLL is the target or the active source.
- R4: After a select change, `busy` is low again within 6 `osc_clk` periods plus 4 `pll_clk` periods. The new source is already driving `sys_clk` by then. The handover itself takes at most 4 periods of each clock, and up to 2 more `osc_clk` periods carry the completion back to `busy`.
- R5: The two sources are never enabled together. Every high and low phase of `sys_clk` lasts at least half a period of the faster input.
- R6: While neither source is enabled, `sys_clk` and `bus_clk` stay low. The first `bus_clk` high phase after a handover lasts a full `sys_clk` period.
- R7: `core_clk` has the period of `sys_clk`. `bus_clk` has twice that period.
- R8: `busy` rises at the first `osc_clk` rising edge after the effective select (`pll_sel` OR `scm_force`) changes. While `busy` is high the target is frozen. A select change made during `busy` starts a second handover after the first one completes.
- R9: After reset, `busy`=0, `pll_en`=0 and `sys_clk` follows `osc_clk`.
- R10: `wd_clk` is `osc_clk` gated by `wd_enable`=1. The gate is off in wait mode when `wd_wait_halt`=1. In stop mode it is on only when `pseudo_stop`=1 and `wd_stop_run`=1.
- R11: `rti_clk` follows the same rules as R10, using `rti_enable`, `rti_stop_run` and `rti_wait_halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Oscillator clock |
| pll_clk | input | 1 | PLL clock, unrelated to osc_clk |
| pll_sel | input | 1 | 1 requests the PLL as source |
| scm_force | input | 1 | Self-clock mode, forces the PLL source |
| pll_en_wr | input | 1 | Write strobe for the PLL enable flag (osc_clk domain) |
| pll_en_wdata | input | 1 | Value written to the PLL enable flag |
| stop_mode | input | 1 | Stop mode active |
| pseudo_stop | input | 1 | Stop mode keeps the oscillator running |
| wait_mode | input | 1 | Wait mode active |
| wd_enable | input | 1 | Watchdog timer enabled |
| wd_stop_run | input | 1 | Watchdog keeps its clock in pseudo stop |
| wd_wait_halt | input | 1 | Watchdog clock halted in wait mode |
| rti_enable | input | 1 | Periodic-interrupt timer enabled |
| rti_stop_run | input | 1 | Periodic-interrupt timer keeps its clock in pseudo stop |
| rti_wait_halt | input | 1 | Periodic-interrupt timer clock halted in wait mode |
| pll_en | output | 1 | PLL enable flag |
| busy | output | 1 | A source handover is in progress |
| sys_clk | output | 1 | Selected system clock |
| core_clk | output | 1 | Core clock, at the system clock rate |
| bus_clk | output | 1 | Bus clock, system clock divided by two |
| wd_clk | output | 1 | Gated clock for the watchdog timer |
| rti_clk | output | 1 | Gated clock for the periodic-interrupt timer |

## Verification
The assertions assume that the mode, enable and write inputs are level signals. They change only between `osc_clk` edges, never on a falling edge where a gate flop samples them. The bench sets every input one nanosecond after an `osc_clk` rising edge, which keeps the PLL enable write and the gate settings clear of both edges. Both input clocks are taken to run without stopping. The bench runs them freely at 4 ns and 7 ns with a phase offset, so every handover crosses at an unrelated alignment. Select changes made during `busy` are issued only after `busy` is seen high, which makes the queued-request case really overlap a running handover.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned GATE_COUNT = 2;

  typedef struct packed {
    logic enable;
    logic stop_run;
    logic wait_halt;
  } tmr_gate_cfg_t;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/cs_handover_side.sv
module cs_handover_side #(
  parameter int unsigned STAGES = 2,
  parameter logic        ON_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic on
);
  logic req_s;
  logic on_d;
  logic on_q;

  cs_sync #(.STAGES(STAGES), .RST_VAL(ON_RST)) req_sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req),
    .q    (req_s)
  );

  always_comb begin
    on_d = req_s;
  end

  // enable changes only while this clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= ON_RST;
    else        on_q <= on_d;
  end

  assign on = on_q;
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic scm,
  input  logic wr,
  input  logic wdata,
  input  logic osc_on,
  input  logic pll_on_s,
  output logic tgt,
  output logic pll_en,
  output logic busy
);
  logic want_pll;
  logic tgt_d, tgt_q;
  logic pll_en_d, pll_en_q;
  logic pll_in_use;

  always_comb begin
    want_pll   = scm | sel;
    busy       = tgt_q ? (~pll_on_s | osc_on) : (~osc_on | pll_on_s);
    tgt_d      = busy ? tgt_q : want_pll;
    pll_in_use = tgt_q | pll_on_s;
    pll_en_d   = pll_en_q;
    if (wr && (wdata || !pll_in_use)) pll_en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q    <= 1'b0;
      pll_en_q <= 1'b0;
    end else begin
      tgt_q    <= tgt_d;
      pll_en_q <= pll_en_d;
    end
  end

  assign tgt    = tgt_q;
  assign pll_en = pll_en_q;

  // R8
  tgt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tgt_q));

  // R3
  pll_en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en_q && (tgt_q || pll_on_s)) |=> pll_en_q);
endmodule

// File: rtl/cs_timer_gate.sv
module cs_timer_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic gclk
);
  logic en_d;
  logic en_q;

  always_comb begin
    en_d = run;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign gclk = clk & en_q;

  // R10, R11
  gate_off_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !run |=> !en_q);
endmodule

// File: rtl/sysclk_selector.sv
module sysclk_selector
  import sysclk_sel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic rst_n,
  input  logic osc_clk,
  input  logic pll_clk,
  input  logic pll_sel,
  input  logic scm_force,
  input  logic pll_en_wr,
  input  logic pll_en_wdata,
  input  logic stop_mode,
  input  logic pseudo_stop,
  input  logic wait_mode,
  input  logic wd_enable,
  input  logic wd_stop_run,
  input  logic wd_wait_halt,
  input  logic rti_enable,
  input  logic rti_stop_run,
  input  logic rti_wait_halt,
  output logic pll_en,
  output logic busy,
  output logic sys_clk,
  output logic core_clk,
  output logic bus_clk,
  output logic wd_clk,
  output logic rti_clk
);
  logic rst_osc_n, rst_pll_n;
  logic tgt;
  logic osc_on, pll_on, pll_on_s;
  logic osc_req, pll_req;
  logic bus_clr_n, bus_d, bus_q;
  tmr_gate_cfg_t        gate_cfg [GATE_COUNT];
  logic [GATE_COUNT-1:0] gate_run;
  logic [GATE_COUNT-1:0] gate_clk;

  // reset release aligned to each domain
  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) rst_osc_i (
    .clk(osc_clk), .rst_n(rst_n), .d(1'b1), .q(rst_osc_n));
  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) rst_pll_i (
    .clk(pll_clk), .rst_n(rst_n), .d(1'b1), .q(rst_pll_n));

  cs_ctrl ctrl_i (
    .clk     (osc_clk),
    .rst_n   (rst_osc_n),
    .sel     (pll_sel),
    .scm     (scm_force),
    .wr      (pll_en_wr),
    .wdata   (pll_en_wdata),
    .osc_on  (osc_on),
    .pll_on_s(pll_on_s),
    .tgt     (tgt),
    .pll_en  (pll_en),
    .busy    (busy)
  );

  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) pll_on_sync_i (
    .clk(osc_clk), .rst_n(rst_osc_n), .d(pll_on), .q(pll_on_s));

  // each side may enable only after the other side is off
  always_comb begin
    osc_req = ~tgt & ~pll_on;
    pll_req =  tgt & ~osc_on;
  end

  cs_handover_side #(.STAGES(SYNC_STAGES), .ON_RST(1'b1)) osc_side_i (
    .clk(osc_clk), .rst_n(rst_osc_n), .req(osc_req), .on(osc_on));
  cs_handover_side #(.STAGES(SYNC_STAGES), .ON_RST(1'b0)) pll_side_i (
    .clk(pll_clk), .rst_n(rst_pll_n), .req(pll_req), .on(pll_on));

  assign sys_clk  = (osc_clk & osc_on) | (pll_clk & pll_on);
  assign core_clk = sys_clk;

  // divider cleared during the gap so it restarts on the new source
  always_comb begin
    bus_clr_n = rst_osc_n & (osc_on | pll_on);
    bus_d     = ~bus_q;
  end

  always_ff @(posedge sys_clk or negedge bus_clr_n) begin
    if (!bus_clr_n) bus_q <= 1'b0;
    else            bus_q <= bus_d;
  end

  assign bus_clk = bus_q;

  always_comb begin
    gate_cfg[0] = '{enable: wd_enable,  stop_run: wd_stop_run,  wait_halt: wd_wait_halt};
    gate_cfg[1] = '{enable: rti_enable, stop_run: rti_stop_run, wait_halt: rti_wait_halt};
  end

  for (genvar g = 0; g < GATE_COUNT; g++) begin : g_tmr_gate
    always_comb begin
      gate_run[g] = gate_cfg[g].enable
                  & ~(stop_mode & ~(pseudo_stop & gate_cfg[g].stop_run))
                  & ~(wait_mode & gate_cfg[g].wait_halt);
    end
    cs_timer_gate gate_i (
      .clk (osc_clk),
      .rst_n(rst_osc_n),
      .run (gate_run[g]),
      .gclk(gate_clk[g])
    );
  end

  assign wd_clk  = gate_clk[0];
  assign rti_clk = gate_clk[1];

  // R5
  src_excl_chk: assert property (@(posedge osc_clk) disable iff (!rst_osc_n)
    !(osc_on && pll_on));

  // R6
  gap_bus_low_chk: assert property (@(posedge osc_clk) disable iff (!rst_osc_n)
    (!osc_on && !pll_on) |-> (!bus_clk && !sys_clk));
endmodule

// File: tb/sysclk_selector_tb_top.sv
`timescale 1ns/1ps
module sysclk_selector_tb_top;
  logic rst_n = 1'b0;
  logic osc_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic pll_sel = 1'b0, scm_force = 1'b0;
  logic pll_en_wr = 1'b0, pll_en_wdata = 1'b0;
  logic stop_mode = 1'b0, pseudo_stop = 1'b0, wait_mode = 1'b0;
  logic wd_enable = 1'b0, wd_stop_run = 1'b0, wd_wait_halt = 1'b0;
  logic rti_enable = 1'b0, rti_stop_run = 1'b0, rti_wait_halt = 1'b0;
  logic pll_en, busy, sys_clk, core_clk, bus_clk, wd_clk, rti_clk;

  localparam real OSC_P = 4.0;
  localparam real PLL_P = 7.0;
  localparam real TOL   = 0.1;
  localparam real BOUND = 6.0 * OSC_P + 4.0 * PLL_P;

  int n_chk = 0, n_err = 0;
  int runt = 0, gap_seen = 0, gap_bad = 0, busy_rises = 0;
  int wd_edges = 0, rti_edges = 0;
  bit mon_on = 1'b0;
  real t_rise = 0.0, t_fall = 0.0;

  always #(OSC_P/2.0) osc_clk = ~osc_clk;
  initial begin
    #1.3;
    forever #(PLL_P/2.0) pll_clk = ~pll_clk;
  end

  sysclk_selector dut_i (
    .rst_n(rst_n), .osc_clk(osc_clk), .pll_clk(pll_clk),
    .pll_sel(pll_sel), .scm_force(scm_force),
    .pll_en_wr(pll_en_wr), .pll_en_wdata(pll_en_wdata),
    .stop_mode(stop_mode), .pseudo_stop(pseudo_stop), .wait_mode(wait_mode),
    .wd_enable(wd_enable), .wd_stop_run(wd_stop_run), .wd_wait_halt(wd_wait_halt),
    .rti_enable(rti_enable), .rti_stop_run(rti_stop_run), .rti_wait_halt(rti_wait_halt),
    .pll_en(pll_en), .busy(busy), .sys_clk(sys_clk), .core_clk(core_clk),
    .bus_clk(bus_clk), .wd_clk(wd_clk), .rti_clk(rti_clk)
  );

  // phase-width monitor on the system clock (R5)
  always @(posedge sys_clk) begin
    if (mon_on && ($realtime - t_fall) < (OSC_P/2.0 - TOL)) runt++;
    t_rise = $realtime;
  end
  always @(negedge sys_clk) begin
    if (mon_on && ($realtime - t_rise) < (OSC_P/2.0 - TOL)) runt++;
    t_fall = $realtime;
  end

  // gap monitor (R6): sys_clk low far longer than any phase
  initial begin
    forever begin
      #0.5;
      if (mon_on && !sys_clk && ($realtime - t_fall) > 5.0) begin
        gap_seen++;
        if (bus_clk) gap_bad++;
      end
    end
  end

  always @(posedge busy)    busy_rises++;
  always @(posedge wd_clk)  wd_edges++;
  always @(posedge rti_clk) rti_edges++;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a > b - TOL) && (a < b + TOL);
  endfunction

  task automatic step();
    @(posedge osc_clk);
    #1;
  endtask

  task automatic period_of_sys(output real p);
    real t1;
    @(posedge sys_clk); t1 = $realtime;
    @(posedge sys_clk); p = $realtime - t1;
  endtask

  task automatic period_of_core(output real p);
    real t1;
    @(posedge core_clk); t1 = $realtime;
    @(posedge core_clk); p = $realtime - t1;
  endtask

  task automatic period_of_bus(output real p);
    real t1;
    @(posedge bus_clk); t1 = $realtime;
    @(posedge bus_clk); p = $realtime - t1;
  endtask

  task automatic write_pll_en(input logic v);
    step();
    pll_en_wr = 1'b1; pll_en_wdata = v;
    step();
    pll_en_wr = 1'b0;
  endtask

  // drive a select change and time the handover
  task automatic switch_and_time(input logic sel_v, input logic scm_v,
                                 input string req, output real dt);
    real t0;
    step();
    pll_sel = sel_v; scm_force = scm_v;
    t0 = $realtime;
    step();
    chk(busy == 1'b1, "R8", "busy raised after select change", real'(busy), 1.0);
    wait (!busy);
    dt = $realtime - t0;
    chk(dt <= BOUND, req, "handover time (ns)", dt, BOUND);
    repeat (4) step();
  endtask

  task automatic t_reset();
    real p;
    rst_n = 1'b0;
    repeat (6) step();
    rst_n = 1'b1;
    repeat (8) step();
    mon_on = 1'b1;
    chk(busy == 1'b0, "R9", "busy after reset", real'(busy), 0.0);
    chk(pll_en == 1'b0, "R9", "pll_en after reset", real'(pll_en), 0.0);
    period_of_sys(p);
    chk(near(p, OSC_P), "R9", "sys_clk period after reset", p, OSC_P);
  endtask

  task automatic t_to_pll();
    real dt, p;
    write_pll_en(1'b1);
    chk(pll_en == 1'b1, "R3", "pll_en written to 1", real'(pll_en), 1.0);
    switch_and_time(1'b1, 1'b0, "R4", dt);
    period_of_sys(p);
    chk(near(p, PLL_P), "R1", "sys_clk period on PLL", p, PLL_P);
    period_of_core(p);
    chk(near(p, PLL_P), "R7", "core_clk period", p, PLL_P);
    period_of_bus(p);
    chk(near(p, 2.0 * PLL_P), "R7", "bus_clk period", p, 2.0 * PLL_P);
  endtask

  task automatic t_protect();
    write_pll_en(1'b0);
    chk(pll_en == 1'b1, "R3", "clear refused while PLL selected", real'(pll_en), 1.0);
  endtask

  task automatic t_to_osc();
    real dt, p;
    switch_and_time(1'b0, 1'b0, "R4", dt);
    period_of_sys(p);
    chk(near(p, OSC_P), "R1", "sys_clk period on oscillator", p, OSC_P);
    period_of_bus(p);
    chk(near(p, 2.0 * OSC_P), "R7", "bus_clk period on oscillator", p, 2.0 * OSC_P);
    write_pll_en(1'b0);
    chk(pll_en == 1'b0, "R3", "clear accepted on oscillator", real'(pll_en), 0.0);
  endtask

  task automatic t_scm();
    real dt, p;
    switch_and_time(1'b0, 1'b1, "R2", dt);
    period_of_sys(p);
    chk(near(p, PLL_P), "R2", "self-clock mode forces PLL", p, PLL_P);
    switch_and_time(1'b0, 1'b0, "R2", dt);
    period_of_sys(p);
    chk(near(p, OSC_P), "R2", "release of self-clock mode", p, OSC_P);
  endtask

  task automatic t_queued();
    int r0;
    real p;
    r0 = busy_rises;
    step();
    pll_sel = 1'b1;
    step();
    step();
    chk(busy == 1'b1, "R8", "busy during first handover", real'(busy), 1.0);
    pll_sel = 1'b0;
    wait (!busy);
    repeat (3) step();
    wait (!busy);
    repeat (4) step();
    chk((busy_rises - r0) == 2, "R8", "handovers for queued change",
        real'(busy_rises - r0), 2.0);
    period_of_sys(p);
    chk(near(p, OSC_P), "R8", "queued change applied", p, OSC_P);
  endtask

  task automatic t_waveform();
    chk(runt == 0, "R5", "runt phases on sys_clk", real'(runt), 0.0);
    chk(gap_seen > 0, "R6", "handover gaps observed", real'(gap_seen), 1.0);
    chk(gap_bad == 0, "R6", "bus_clk high during gap", real'(gap_bad), 0.0);
  endtask

  task automatic gate_case(input logic wen, input logic wsr, input logic wwh,
                           input logic ren, input logic rsr, input logic rwh,
                           input logic st, input logic ps, input logic wt,
                           input bit exp_wd, input bit exp_rti, input string tag);
    int w0, r0, wd_n, rti_n;
    step();
    wd_enable = wen; wd_stop_run = wsr; wd_wait_halt = wwh;
    rti_enable = ren; rti_stop_run = rsr; rti_wait_halt = rwh;
    stop_mode = st; pseudo_stop = ps; wait_mode = wt;
    repeat (3) step();
    w0 = wd_edges; r0 = rti_edges;
    repeat (20) step();
    wd_n = wd_edges - w0; rti_n = rti_edges - r0;
    chk(exp_wd ? (wd_n >= 19 && wd_n <= 21) : (wd_n == 0), "R10",
        {"wd_clk edges, ", tag}, real'(wd_n), exp_wd ? 20.0 : 0.0);
    chk(exp_rti ? (rti_n >= 19 && rti_n <= 21) : (rti_n == 0), "R11",
        {"rti_clk edges, ", tag}, real'(rti_n), exp_rti ? 20.0 : 0.0);
  endtask

  task automatic t_gates();
    gate_case(1,0,0, 1,0,0, 0,0,0, 1,1, "run mode");
    gate_case(0,0,0, 1,0,0, 0,0,0, 0,1, "watchdog disabled");
    gate_case(1,0,1, 1,0,0, 0,0,1, 0,1, "wait mode");
    gate_case(1,1,0, 1,1,0, 1,0,0, 0,0, "full stop");
    gate_case(1,1,0, 1,0,0, 1,1,0, 1,0, "pseudo stop");
    gate_case(1,0,0, 0,0,0, 0,0,0, 1,0, "timer disabled");
  endtask

  initial begin
    #(200000.0 * OSC_P);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_to_pll();
    t_protect();
    t_to_osc();
    t_scm();
    t_queued();
    t_waveform();
    t_gates();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule